// File: doc/BRIEF.md
# Dual-Channel Up-Counting Timer

The block is a memory-mapped timer with two independent 16-bit channels that share one functional clock. Each channel divides that clock by a programmable power of two. It counts the divided ticks upward from zero until the count matches a programmed terminal value. At that point it raises a pending event. It then either starts again from zero (repeating mode) or stops itself (single-shot mode).

Software reaches four word registers per channel through a small synchronous bus with 16-bit data: a control word, an event status word, a terminal value and the live count. The live count can be read at any time. Loaded with the full 16-bit value in repeating mode, the count serves as a free-running time base. Each channel drives a level interrupt line that is high while its event is pending and its interrupt enable is set.

Top module: `gp_timer`

## Requirements
- R1: Channel n (n = 0, 1) occupies byte offsets 0x80 + n*0x80 with control at +0x0, status at +0x4, terminal value at +0x8 and count at +0xC. A read presented on one clock edge returns its data on `bus_rdata` after that edge. After reset every register reads zero and both interrupt lines are low.
- R2: The control word has interrupt enable at bit 8, run enable at bit 5, single-shot select at bit 4 and the divider code at bits [3:0]. All other bits read as zero. A code above 8 is stored, and reads back, as 8.
- R3: A running channel with divider code c produces one tick every 2^c clock cycles. Each tick advances the count by one.
- R4: A control write that changes run enable from 0 to 1 clears both the count and the divider phase, so the first tick follows 2^c cycles later.
- R5: The status bit 0 sets on the tick that brings the count to the terminal value T. For T from 3 to 0xFFF0, this happens exactly T ticks after the start.
- R6: In repeating mode (bit 4 clear), the tick after the count reaches T returns the count to zero. With T = 0xFFFF, the count wraps through the full 16-bit range.
- R7: In single-shot mode, the channel clears its own run enable when the count reaches T, and the count then holds at T.
- R8: Clearing run enable stops the count, which then holds its value. The terminal value may be rewritten while the channel is stopped.
- R9: Writing 1 to status bit 0 clears the pending event. Writing 0 leaves it unchanged. If an event and a clearing write fall on the same edge, the event stays pending.
- R10: A channel's interrupt line is high exactly while its pending bit and its interrupt enable are both set.
- R11: Reads of any other offset, including misaligned ones, return zero. Writes to such offsets, and writes to the count register, change nothing.
- R12: Writing one channel's control word, including a change of its divider code, does not disturb the other channel's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock shared by both channels and the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered on the edge of the read |
| irq | output | 2 | Level interrupt, one line per channel |

## Verification
On every cycle, the assertions check the following: an enable start leaves a zero count, the pending bit rises only on a divider tick, the count wraps in repeating mode and stops at the terminal value in single-shot mode, a stopped count holds, an event beats a same-edge clear, and unused offsets read zero. Only the bench's scenarios can show the tick spacing for each divider code, the exact tick at which an event lands for small, mid-range and near-full terminal values, and the full 16-bit wrap. They also show the clamping of oversized divider codes, the interrupt masking, and the fact that reprogramming one channel leaves the other's count intact.

// File: rtl/gpt_pkg.sv
`timescale 1ns/1ps
// Package gpt_pkg
// Holds the control-word bit positions, the register selector encoding and
// the address split that are shared by the timer modules.
// Assumes byte addressing with 32-bit-aligned register slots.
package gpt_pkg;
    localparam int CTRL_IE_BIT = 8;
    localparam int CTRL_EN_BIT = 5;
    localparam int CTRL_OS_BIT = 4;
    localparam int BANK_SHIFT  = 7;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_STAT  = 2'd1,
        REG_LOAD  = 2'd2,
        REG_COUNT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpt_prescaler.sv
`timescale 1ns/1ps
// Module gpt_prescaler
// Divides the functional clock by 2^code and emits a one-cycle tick at the
// end of each divided period while run is high.
// Assumes code never exceeds MAX_CODE (the channel clamps it). A restart
// pulse returns the phase to zero.
module gpt_prescaler #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int DIV_W = (MAX_CODE > 0) ? MAX_CODE : 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W:0]   term;

    // Last phase value of the divided period for the current code
    always_comb term = (DIV_W+1)'((1 << code) - 1);

    // Tick when the phase has reached (or passed, after a code change) the end
    always_comb tick = run && !restart && ({1'b0, phase_q} >= term);

    // Phase counter: cleared on restart or tick, advanced while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || tick) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/gpt_channel.sv
`timescale 1ns/1ps
// Module gpt_channel
// One timer channel: control fields, terminal value, up-counter, pending
// event and masked level interrupt.
// Assumes the bus decoder asserts at most one write strobe per cycle and
// presents only the control fields this channel stores.
module gpt_channel #(
    parameter int CNT_W    = 16,
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              stat_we,
    input  logic              load_we,
    input  logic              wr_ie,
    input  logic              wr_en,
    input  logic              wr_os,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_clr,
    input  logic [CNT_W-1:0]  wr_load,
    output logic              ie_q,
    output logic              en_q,
    output logic              os_q,
    output logic [CODE_W-1:0] code_q,
    output logic              pend_q,
    output logic [CNT_W-1:0]  load_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              irq
);
    logic              tick;
    logic              start;
    logic              at_term;
    logic              reach;
    logic              event_hit;
    logic [CODE_W-1:0] code_in;

    // Oversized divider codes saturate at the largest supported divide
    always_comb code_in = (wr_code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : wr_code;

    // A start is a control write that turns a stopped channel on
    always_comb start = ctrl_we && wr_en && !en_q;

    // Compare the count with the terminal value, now and one step ahead
    always_comb begin
        at_term   = (count_q == load_q);
        reach     = !at_term && ((count_q + CNT_W'(1)) == load_q);
        event_hit = tick && reach;
    end

    gpt_prescaler #(
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE)
    ) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (en_q),
        .restart (start),
        .code    (code_q),
        .tick    (tick)
    );

    // Control fields: bus writes first, then single-shot self-stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            en_q   <= 1'b0;
            os_q   <= 1'b0;
            code_q <= '0;
        end else if (ctrl_we) begin
            ie_q   <= wr_ie;
            en_q   <= wr_en;
            os_q   <= wr_os;
            code_q <= code_in;
        end else if (event_hit && os_q) begin
            en_q   <= 1'b0;
        end
    end

    // Terminal value register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (load_we) begin
            load_q <= wr_load;
        end
    end

    // Up-counter: zero on start, advance per tick, wrap after the terminal value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (start) begin
            count_q <= '0;
        end else if (tick) begin
            if (at_term) begin
                count_q <= '0;
            end else begin
                count_q <= count_q + CNT_W'(1);
            end
        end
    end

    // Pending event: a new event outranks a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (event_hit) begin
            pend_q <= 1'b1;
        end else if (stat_we && wr_clr) begin
            pend_q <= 1'b0;
        end
    end

    // Level interrupt gated by the enable
    always_comb irq = pend_q && ie_q;

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count_q == '0)); // R4

    AST_PEND_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(tick)); // R5

    AST_AUTO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_term && !start) |=> (count_q == '0)); // R6

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && reach && os_q && !ctrl_we && !load_we) |=> (!en_q && (count_q == load_q))); // R7

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ctrl_we) |=> $stable(count_q)); // R8

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (event_hit && stat_we && wr_clr) |=> pend_q); // R9
endmodule

// File: rtl/gp_timer.sv
`timescale 1ns/1ps
// Module gp_timer
// Multi-channel timer top: decodes the register bus into per-channel
// strobes, instantiates the channels and registers the read data.
// Assumes byte offsets, one access per cycle, and a register bank of
// 0x80 bytes per channel starting at offset 0x80.
module gp_timer #(
    parameter int NUM_CH   = 2,
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 16,
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    import gpt_pkg::*;

    localparam int BANK_W = ADDR_W - BANK_SHIFT;

    logic [BANK_W-1:0] bank;
    logic              slot_ok;
    reg_sel_e          reg_sel;
    logic [NUM_CH-1:0] hit_ch;
    logic [DATA_W-1:0] rd_mux;

    logic [DATA_W-1:0] ch_ctrl  [NUM_CH];
    logic [DATA_W-1:0] ch_stat  [NUM_CH];
    logic [DATA_W-1:0] ch_load  [NUM_CH];
    logic [DATA_W-1:0] ch_count [NUM_CH];

    // Split the offset into bank, slot and alignment checks
    always_comb begin
        bank    = bus_addr[ADDR_W-1:BANK_SHIFT];
        slot_ok = (bus_addr[BANK_SHIFT-1:4] == '0) && (bus_addr[1:0] == 2'b00);
        reg_sel = reg_sel_e'(bus_addr[3:2]);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic ie, en, os, pend;
        logic [CODE_W-1:0] code;
        logic wr_hit;

        // Channel i owns bank i+1
        always_comb begin
            hit_ch[i] = slot_ok && (bank == BANK_W'(i + 1));
            wr_hit    = bus_en && bus_we && hit_ch[i];
        end

        gpt_channel #(
            .CNT_W    (DATA_W),
            .CODE_W   (CODE_W),
            .MAX_CODE (MAX_CODE)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (wr_hit && (reg_sel == REG_CTRL)),
            .stat_we (wr_hit && (reg_sel == REG_STAT)),
            .load_we (wr_hit && (reg_sel == REG_LOAD)),
            .wr_ie   (bus_wdata[CTRL_IE_BIT]),
            .wr_en   (bus_wdata[CTRL_EN_BIT]),
            .wr_os   (bus_wdata[CTRL_OS_BIT]),
            .wr_code (bus_wdata[CODE_W-1:0]),
            .wr_clr  (bus_wdata[0]),
            .wr_load (bus_wdata),
            .ie_q    (ie),
            .en_q    (en),
            .os_q    (os),
            .code_q  (code),
            .pend_q  (pend),
            .load_q  (ch_load[i]),
            .count_q (ch_count[i]),
            .irq     (irq[i])
        );

        // Assemble the readable control and status words, reserved bits zero
        always_comb begin
            ch_ctrl[i]              = '0;
            ch_ctrl[i][CTRL_IE_BIT] = ie;
            ch_ctrl[i][CTRL_EN_BIT] = en;
            ch_ctrl[i][CTRL_OS_BIT] = os;
            ch_ctrl[i][CODE_W-1:0]  = code;
            ch_stat[i]              = '0;
            ch_stat[i][0]           = pend;
        end
    end

    // Read multiplexer: zero unless a channel slot is addressed
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_ch[i]) begin
                case (reg_sel)
                    REG_CTRL:  rd_mux = ch_ctrl[i];
                    REG_STAT:  rd_mux = ch_stat[i];
                    REG_LOAD:  rd_mux = ch_load[i];
                    default:   rd_mux = ch_count[i];
                endcase
            end
        end
    end

    // Read data register, updated on each read access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_en && !bus_we) begin
            bus_rdata <= rd_mux;
        end
    end

    AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && (hit_ch == '0)) |=> (bus_rdata == '0)); // R11
endmodule

// File: tb/gp_timer_tb.sv
`timescale 1ns/1ps
module gp_timer_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gp_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic [3:0]  code;
        logic        os;
        logic [15:0] load;
        logic [17:0] wait_n;
        logic [15:0] exp_cnt;
        logic        exp_pend;
    } vec_t;

    // Expected count = ticks mod (T+1) in repeating mode, min(ticks,T) in
    // single-shot mode, with ticks = wait >> code (R3, R5, R6, R7)
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  1'b0, 16'd3,      18'd2,     16'd2,      1'b0},
        '{4'd0,  1'b0, 16'd3,      18'd3,     16'd3,      1'b1},
        '{4'd0,  1'b0, 16'd3,      18'd4,     16'd0,      1'b1},
        '{4'd0,  1'b1, 16'd5,      18'd20,    16'd5,      1'b1},
        '{4'd2,  1'b0, 16'd10,     18'd39,    16'd9,      1'b0},
        '{4'd2,  1'b0, 16'd10,     18'd40,    16'd10,     1'b1},
        '{4'd8,  1'b0, 16'd3,      18'd767,   16'd2,      1'b0},
        '{4'd8,  1'b0, 16'd3,      18'd768,   16'd3,      1'b1},
        '{4'd4,  1'b0, 16'd100,    18'd1700,  16'd5,      1'b1},
        '{4'd1,  1'b1, 16'd7,      18'd13,    16'd6,      1'b0},
        '{4'd12, 1'b0, 16'd3,      18'd768,   16'd3,      1'b1},
        '{4'd0,  1'b0, 16'hFFF0,   18'd65520, 16'hFFF0,   1'b1},
        '{4'd0,  1'b0, 16'hFFFF,   18'd65538, 16'd2,      1'b1}
    };

    function automatic logic [8:0] ra(input int ch, input int slot);
        return 9'(9'h080 + ch * 9'h080 + slot * 4);
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; the write happens on the next rising edge
    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and register placement
        rd(ra(0, 0), d); check("R1 ctrl0 reset", d, 16'h0000);
        rd(ra(0, 3), d); check("R1 count0 reset", d, 16'h0000);
        rd(ra(0, 1), d); check("R1 stat0 reset", d, 16'h0000);
        rd(ra(1, 0), d); check("R1 ctrl1 reset", d, 16'h0000);
        check("R1 irq reset", {14'b0, irq}, 16'h0000);
        wr(ra(1, 2), 16'hBEEF);
        rd(ra(1, 2), d); check("R1 load1 slot", d, 16'hBEEF);

        // Vector table: R3 R5 R6 R7 (and R2 code clamp in the 4'd12 row)
        for (int v = 0; v < NV; v++) begin
            wr(ra(0, 0), 16'h0000);
            wr(ra(0, 1), 16'h0001);
            wr(ra(0, 2), VECS[v].load);
            wr(ra(0, 0), 16'h0120 | (16'(VECS[v].os) << 4) | 16'(VECS[v].code));
            repeat (int'(VECS[v].wait_n)) @(negedge clk);
            check($sformatf("R5 R10 irq vec %0d", v), {15'b0, irq[0]}, {15'b0, VECS[v].exp_pend});
            rd(ra(0, 3), d);
            check($sformatf("R3 R6 count vec %0d", v), d, VECS[v].exp_cnt);
            check($sformatf("R12 idle irq1 vec %0d", v), {15'b0, irq[1]}, 16'h0000);
        end

        // R2: field readback, reserved bits zero, code clamp
        wr(ra(0, 0), 16'hFFFF);
        rd(ra(0, 0), d); check("R2 ctrl readback", d, 16'h0138);
        wr(ra(0, 0), 16'h0000);

        // R8 stop/hold and R4 restart from zero
        wr(ra(0, 1), 16'h0001);
        wr(ra(0, 2), 16'd100);
        wr(ra(0, 0), 16'h0020);
        repeat (10) @(negedge clk);
        wr(ra(0, 0), 16'h0000);
        repeat (20) @(negedge clk);
        rd(ra(0, 3), d); check("R8 stopped count holds", d, 16'd11);
        wr(ra(0, 2), 16'd4);
        rd(ra(0, 2), d); check("R8 load written while stopped", d, 16'd4);
        wr(ra(0, 0), 16'h0020);
        repeat (2) @(negedge clk);
        rd(ra(0, 3), d); check("R4 restart from zero", d, 16'd2);
        wr(ra(0, 0), 16'h0000);

        // R9 event beats same-edge clear; R7 single-shot stop
        wr(ra(0, 1), 16'h0001);
        wr(ra(0, 2), 16'd3);
        wr(ra(0, 0), 16'h0130);
        repeat (2) @(negedge clk);
        wr(ra(0, 1), 16'h0001);
        check("R9 event wins irq", {15'b0, irq[0]}, 16'h0001);
        rd(ra(0, 1), d); check("R9 event wins stat", d, 16'h0001);
        wr(ra(0, 1), 16'h0000);
        rd(ra(0, 1), d); check("R9 write zero keeps", d, 16'h0001);
        rd(ra(0, 0), d); check("R7 enable self-cleared", d, 16'h0110);
        repeat (10) @(negedge clk);
        rd(ra(0, 3), d); check("R7 count holds at load", d, 16'd3);

        // R10 interrupt masking
        wr(ra(0, 0), 16'h0010);
        check("R10 masked irq", {15'b0, irq[0]}, 16'h0000);
        rd(ra(0, 1), d); check("R10 pending kept while masked", d, 16'h0001);
        wr(ra(0, 0), 16'h0110);
        check("R10 unmasked irq", {15'b0, irq[0]}, 16'h0001);
        wr(ra(0, 1), 16'h0001);
        check("R9 clear drops irq", {15'b0, irq[0]}, 16'h0000);

        // R11 unused offsets and read-only count
        rd(9'h090, d); check("R11 read +0x10", d, 16'h0000);
        rd(9'h000, d); check("R11 read 0x000", d, 16'h0000);
        rd(9'h180, d); check("R11 read absent bank", d, 16'h0000);
        rd(9'h082, d); check("R11 read misaligned", d, 16'h0000);
        wr(9'h000, 16'hFFFF);
        wr(9'h094, 16'hFFFF);
        wr(9'h180, 16'hFFFF);
        wr(9'h081, 16'hFFFF);
        rd(ra(0, 0), d); check("R11 ctrl0 untouched", d, 16'h0110);
        rd(ra(1, 0), d); check("R11 ctrl1 untouched", d, 16'h0000);
        wr(ra(0, 3), 16'h1234);
        rd(ra(0, 3), d); check("R11 count read-only", d, 16'd3);

        // R12 channel independence under divider changes
        wr(ra(0, 0), 16'h0000);
        wr(ra(1, 2), 16'hFFFF);
        wr(ra(1, 0), 16'h0020);
        wr(ra(0, 0), 16'h0023);
        wr(ra(0, 0), 16'h0027);
        wr(ra(0, 0), 16'h0021);
        rd(ra(1, 3), d); check("R12 ch1 count undisturbed", d, 16'd3);
        rd(ra(1, 0), d); check("R12 ch1 ctrl undisturbed", d, 16'h0020);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule